// File: doc/BRIEF.md
# Serial Flash Byte Shifter

This block is a register-fed SPI master for a serial NOR flash. Software places up to four bytes in a 32-bit data word and then posts a 4-bit operation code. The engine clocks 1 to 4 bytes out of the data word, or clocks 1 to 4 bytes in from the flash and packs them into the data word. When the transfer ends it either releases chip select or keeps it asserted. Keeping it asserted lets the next operation continue the same flash command.

Software builds each flash command from a chain of these operations. For a fast read, it sends opcode 0x0B with a 24-bit address, the most significant address byte going out first. It then reads one dummy byte, then the data. Page program is 0x02, sector erase 0xD8, write enable 0x06, write disable 0x04 and status read 0x05. The flash holds 512 KiB in 64 KiB sectors, and word reads must be 4-byte aligned and stay inside that range. Software enforces these limits; the engine does not.

The controller has four states:
- `S_IDLE` waits for a request, and an operation moves it to `S_LOW`.
- `S_LOW` holds SCK low for one half period. At the end of the half period it moves to `S_HIGH` and samples MISO.
- `S_HIGH` holds SCK high for one half period. It then returns to `S_LOW` for the next bit, or moves to `S_DONE` after the last bit.
- `S_DONE` stores read data, decides whether chip select stays asserted, and returns to `S_IDLE`.

Top module: `sflash_byte_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and `data_rdata` is 0.
- R2: The operation code uses these bits: bit 0 is the direction (1 = send the data word, 0 = receive), bits [2:1] are the byte count minus one, and bit 3 is continue. An accepted operation produces exactly 8×(count) rising SCK edges.
- R3: On a send operation, bytes leave the data word starting at bits [7:0] and moving upward. Within each byte the most significant bit goes first. The bus uses SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MOSI is valid at each rising edge.
- R4: On a receive operation, the first byte received lands in bits [7:0] and later bytes fill upward. Bytes beyond the count read as zero. The data word changes only when the transfer completes.
- R5: Chip select is low for the whole of every transfer. After a transfer with continue set it stays low; otherwise it returns high.
- R6: `busy` goes high in the cycle after an accepted `op_wr` and stays high until completion. An `op_wr` while busy is ignored.
- R7: A `data_wr` while idle loads the data word. A `data_wr` while busy is ignored and does not alter the bytes being sent.
- R8: Each SCK high phase and each SCK low phase lasts `SCK_HALF` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | Strobe to load the data word |
| data_wdata | input | 32 | New data word value |
| op_wr | input | 1 | Strobe to post an operation |
| op_cmd | input | 4 | Operation code: continue, count minus one, direction |
| data_rdata | output | 32 | Current data word |
| busy | output | 1 | Transfer in progress |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench checks byte and bit order using asymmetric patterns, so a design that reversed byte order or sent each byte LSB first would capture a different word. It checks every byte count: a counter that was off by one would show a wrong number of SCK edges, and a read that failed to clear unused bytes would leak stale upper bytes. A chained command (address send, then dummy read, then data read) shows whether chip select really stays low across operations. Requests posted mid-transfer check whether the design drops them: a design that accepted a second operation would add SCK edges, and one that accepted a second data write would corrupt the outgoing bytes.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int SFE_WORD_BYTES = 4;
    localparam int SFE_WORD_W     = 8 * SFE_WORD_BYTES;
    localparam int SFE_BYTE_IDX_W = $clog2(SFE_WORD_BYTES);
    localparam int SFE_BIT_IDX_W  = $clog2(SFE_WORD_W);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_DONE = 2'd3
    } sfe_state_e;

    // Operation code; the field positions are the software contract.
    typedef struct packed {
        logic                      cont;
        logic [SFE_BYTE_IDX_W-1:0] cnt_m1;
        logic                      dir_out;
    } sfe_op_t;
endpackage

// File: rtl/sfe_half_timer.sv
module sfe_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sfe_rx_collect.sv
module sfe_rx_collect #(
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      sample,
    input  logic [$clog2(WORD_W)-1:0] bit_pos,
    input  logic                      din,
    output logic [WORD_W-1:0]         word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (sample) begin
            word[bit_pos] <= din;
        end
    end
endmodule

// File: rtl/sflash_byte_engine.sv
module sflash_byte_engine
    import sfe_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_wr,
    input  logic [31:0] data_wdata,
    input  logic        op_wr,
    input  logic [3:0]  op_cmd,
    output logic [31:0] data_rdata,
    output logic        busy,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam logic [2:0] TOP_BIT = 3'd7;

    sfe_state_e                state_q, state_d;
    sfe_op_t                   op_q;
    logic [SFE_BYTE_IDX_W-1:0] byte_q;
    logic [2:0]                bit_q;
    logic                      cs_hold_q;
    logic [SFE_WORD_W-1:0]     data_q;
    logic [SFE_WORD_W-1:0]     rx_word;
    logic                      tick;
    logic                      last_bit;
    logic                      start;
    logic [SFE_BIT_IDX_W-1:0]  bit_pos;

    assign start    = (state_q == S_IDLE) && op_wr;
    assign last_bit = (byte_q == op_q.cnt_m1) && (bit_q == 3'd0);
    assign bit_pos  = {byte_q, bit_q};

    sfe_half_timer #(.HALF(SCK_HALF)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart ((state_q == S_IDLE) || (state_q == S_DONE)),
        .tick    (tick)
    );

    sfe_rx_collect #(.WORD_W(SFE_WORD_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .sample  ((state_q == S_LOW) && tick && !op_q.dir_out),
        .bit_pos (bit_pos),
        .din     (spi_miso),
        .word    (rx_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (op_wr) state_d = S_LOW;
            S_LOW:  if (tick)  state_d = S_HIGH;
            S_HIGH: if (tick)  state_d = last_bit ? S_DONE : S_LOW;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Operation, bit position, chip-select hold and data word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            byte_q    <= '0;
            bit_q     <= TOP_BIT;
            cs_hold_q <= 1'b0;
            data_q    <= '0;
        end else begin
            if (state_q == S_IDLE && data_wr) begin
                data_q <= data_wdata;
            end
            if (start) begin
                op_q      <= sfe_op_t'(op_cmd);
                byte_q    <= '0;
                bit_q     <= TOP_BIT;
                cs_hold_q <= 1'b1;
            end
            if (state_q == S_HIGH && tick && !last_bit) begin
                if (bit_q == 3'd0) begin
                    bit_q  <= TOP_BIT;
                    byte_q <= byte_q + 1'b1;
                end else begin
                    bit_q <= bit_q - 1'b1;
                end
            end
            if (state_q == S_DONE) begin
                cs_hold_q <= op_q.cont;
                if (!op_q.dir_out) data_q <= rx_word;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        spi_sck    = (state_q == S_HIGH);
        spi_cs_n   = !(busy || cs_hold_q);
        spi_mosi   = op_q.dir_out && busy && data_q[bit_pos];
        data_rdata = data_q;
    end

    a_r5_cs_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !spi_cs_n);
    a_r3_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sck);
    a_r6_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_wr));
    a_r4_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != S_DONE) |=> $stable(data_rdata));
    a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
endmodule

// File: tb/test_sflash_byte_engine.sv
module test_sflash_byte_engine;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_wr = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        op_wr = 1'b0;
    logic [3:0]  op_cmd = '0;
    logic [31:0] data_rdata;
    logic        busy, spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    sflash_byte_engine #(.SCK_HALF(HALF)) i_sflash_byte_engine (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
        .op_wr(op_wr), .op_cmd(op_cmd), .data_rdata(data_rdata), .busy(busy),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Flash responder: counts edges, captures MOSI, drives MISO MSB first.
    int          edges = 0;
    int          base = 0;
    int          hi_cnt = 0;
    logic [31:0] sl_cap = '0;
    logic [31:0] sl_tx = '0;

    always @(posedge spi_sck) begin
        int k;
        k = edges - base;
        if (k >= 0 && k < 32) sl_cap[(k / 8) * 8 + 7 - (k % 8)] = spi_mosi;
        edges = edges + 1;
    end

    always @(negedge clk) if (spi_sck) hi_cnt = hi_cnt + 1;

    always_comb begin
        int k;
        k = edges - base;
        spi_miso = (k >= 0 && k < 32) ? sl_tx[(k / 8) * 8 + 7 - (k % 8)] : 1'b0;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic post_op(input logic [3:0] op, input logic [31:0] wd,
                           input logic [31:0] slv, output int hb);
        @(negedge clk);
        data_wr = 1'b1; data_wdata = wd;
        @(negedge clk);
        data_wr = 1'b0;
        base = edges; hb = hi_cnt; sl_cap = '0; sl_tx = slv;
        op_wr = 1'b1; op_cmd = op;
        @(negedge clk);
        op_wr = 1'b0;
    endtask

    // Vector table: {op[3:0], data word, responder word}
    localparam int NV = 9;
    localparam logic [67:0] VEC [NV] = '{
        {4'b0001, 32'h0000_00A5, 32'h0000_0000},
        {4'b0011, 32'h0000_3C81, 32'h0000_0000},
        {4'b0111, 32'h1234_5678, 32'h0000_0000},
        {4'b0000, 32'hFFFF_FFFF, 32'h0000_005E},
        {4'b0100, 32'h0BAD_0BAD, 32'hFFC3_A501},
        {4'b0110, 32'h0000_0000, 32'h8001_FE7F},
        {4'b1111, 32'h4523_010B, 32'h0000_0000},
        {4'b1000, 32'h0000_0000, 32'h0000_00E7},
        {4'b0110, 32'h0000_0000, 32'hC0DE_F00D}
    };

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int hb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
        chk("R1 sck", {31'b0, spi_sck}, 32'h0);
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 data", data_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [3:0]  op;
            logic [31:0] wd, slv, m;
            int          n;
            op  = VEC[v][67:64];
            wd  = VEC[v][63:32];
            slv = VEC[v][31:0];
            n   = op[2:1] + 1;
            m   = mask_of(n);
            post_op(op, wd, slv, hb);
            chk("R6 busy after op", {31'b0, busy}, 32'h1);
            chk("R5 cs low in transfer", {31'b0, spi_cs_n}, 32'h0);
            wait_idle();
            @(negedge clk);
            chk("R2 sck edge count", edges - base, 8 * n);
            chk("R8 sck high cycles", hi_cnt - hb, 8 * n * HALF);
            if (op[0]) begin
                chk("R3 bytes on mosi", sl_cap & m, wd & m);
                chk("R7 data kept after send", data_rdata, wd);
            end else begin
                chk("R4 packed read", data_rdata, slv & m);
            end
            chk("R5 cs after op", {31'b0, spi_cs_n}, {31'b0, !op[3]});
        end

        // R6: second op while busy is dropped
        post_op(4'b0001, 32'h0000_0099, 32'h0, hb);
        repeat (4) @(negedge clk);
        op_wr = 1'b1; op_cmd = 4'b0110;
        @(negedge clk);
        op_wr = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R6 dropped op edges", edges - base, 8);
        chk("R6 stays idle", {31'b0, busy}, 32'h0);
        chk("R6 sent byte", sl_cap & 32'hFF, 32'h99);

        // R7: data write during send ignored; R4: data held during read
        post_op(4'b0111, 32'h1122_3344, 32'h0, hb);
        repeat (5) @(negedge clk);
        data_wr = 1'b1; data_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        data_wr = 1'b0;
        wait_idle();
        @(negedge clk);
        chk("R7 mosi unaffected", sl_cap, 32'h1122_3344);
        chk("R7 data unaffected", data_rdata, 32'h1122_3344);

        post_op(4'b0110, 32'h5555_AAAA, 32'h0F1E_2D3C, hb);
        repeat (20) @(negedge clk);
        chk("R4 held mid read", data_rdata, 32'h5555_AAAA);
        wait_idle();
        @(negedge clk);
        chk("R4 final read", data_rdata, 32'h0F1E_2D3C);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule